// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the device end of a three-line serial control link. A host drives a frame strobe line, a bit clock line and a data line. The block decodes a frame of 8 address bits followed by 24 data bits. Write frames are staged and go into one of two 24-bit control registers only when the frame closes. Read frames make the block drive a 24-bit word back on its own data output, one bit per bit clock.

The bus lines have no timing relation to the local clock. The local clock runs without pause and oversamples all three lines. Each line passes through a two-flop synchroniser, and the block finds edges by comparing successive synchronised samples. Each line level must therefore stay put for at least three local clock cycles. If the local clock stops, the block misses bus activity.

On the core side the block presents both register values, a one-cycle commit strobe with a select bit, and a 24-bit status input that read frames can return.

Top module: `tw_target`

## Requirements
- R1: Reset sets both control registers to zero, holds the commit strobe low and the output enable low, and drives the serial data output high.
- R2: Bits are taken on each rising edge of the bit clock, least significant bit first. The first 8 form the address and the next 24 form the data word, so data bit k is the (k+9)th bit of the frame.
- R3: Address bit 0 sets the direction (0 = write, 1 = read). Address 0x60/0x61 selects control register A and 0x62/0x63 selects register B. A frame with any other address leaves every output unchanged.
- R4: A write reaches its register only on the falling edge of the frame strobe that closes the frame. Until then both registers keep their old values. The commit strobe is high for exactly one cycle, and the select bit reads 0 for register A and 1 for register B.
- R5: A write frame is committed only if exactly 32 rising bit-clock edges fell between the frame strobe falling edges that open and close it. A frame with fewer or more edges is dropped.
- R6: A frame is dropped, and a read frame is not answered, unless the frame strobe was low at address bit 0 and high at every bit from address bit 4 onward.
- R7: For a valid read, the word is captured in parallel on the bit-clock falling edge that follows the 8th rising edge, and its bit 0 appears at once on the serial output. Each later falling edge moves out the next bit. The output enable stays high from the capture until the frame strobe falls. The serial output reads 1 whenever the enable is low.
- R8: A read of 0x61 returns the status input as it stood at the capture, and later changes to the status input do not affect it. A read of 0x63 returns the value of register B.
- R9: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Active-low reset |
| sio_clk | input | 1 | Serial bit clock from the host (asynchronous) |
| sio_period | input | 1 | Frame strobe from the host (asynchronous) |
| sio_data_in | input | 1 | Serial data from the host (asynchronous) |
| status_word | input | 24 | Status value returned by reads of 0x61 |
| sio_data_out | output | 1 | Serial read data |
| sio_data_oe | output | 1 | High while the block drives read data |
| ctrl_a | output | 24 | Control register A |
| ctrl_b | output | 24 | Control register B |
| commit_stb | output | 1 | One-cycle pulse when a register is written |
| commit_sel | output | 1 | Register written at the strobe (0 = A, 1 = B) |

## Verification
The assertions assume that every bus line holds each level long enough for the synchroniser to present it as one clean edge. They also assume that a frame strobe edge and a bit-clock edge never reach the synchronised side in the same cycle. From those two assumptions, commit pulses are isolated, a capture happens only at address count 8, and the enable rises only after a capture. The stimulus keeps each line level for four local cycles and changes one line at a time. Even the malformed frames (short, long, wrong strobe level) follow that pacing, so only the frame content breaks the rules and the edge timing never does.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } sel_e;
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
    parameter int               LINES = 3,
    parameter logic [LINES-1:0] IDLE  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    typedef struct packed {
        logic [LINES-1:0] meta;
        logic [LINES-1:0] stable;
        logic [LINES-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{meta: IDLE, stable: IDLE, prev: IDLE};
        end else begin
            sync_q <= sync_d;
        end
    end

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        assign rise[gi] = sync_q.stable[gi] & ~sync_q.prev[gi];
        assign fall[gi] = ~sync_q.stable[gi] & sync_q.prev[gi];
    end

    assign level = sync_q.stable;
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
    import tw_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                DATA_W        = 24,
    parameter logic [ADDR_W-1:0] ADDR_A        = 8'h60,
    parameter logic [ADDR_W-1:0] ADDR_B        = 8'h62,
    parameter int                PERIOD_SWITCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              strobe_fall,
    input  logic              strobe_lvl,
    input  logic              data_lvl,
    output logic              wr_a,
    output logic              wr_b,
    output logic [DATA_W-1:0] wr_data,
    output logic              ld_status,
    output logic              ld_regb,
    output logic              rd_shift,
    output logic              rd_stop
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER   = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_ADDR   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_SWITCH = CNT_W'(PERIOD_SWITCH);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] bits;
        logic               bad;
        logic               wr_a;
        logic               wr_b;
        logic               ld_s;
        logic               ld_b;
        logic               shift;
        logic               stop;
    } rx_t;

    rx_t rx_d, rx_q;

    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] addr_base;
    dir_e              dir;
    logic              hit_a;
    logic              hit_b;

    always_comb begin
        addr      = rx_q.bits[ADDR_W-1:0];
        addr_base = {addr[ADDR_W-1:1], 1'b0};
        dir       = dir_e'(addr[0]);
        hit_a     = (addr_base == ADDR_A);
        hit_b     = (addr_base == ADDR_B);

        rx_d       = rx_q;
        rx_d.wr_a  = 1'b0;
        rx_d.wr_b  = 1'b0;
        rx_d.ld_s  = 1'b0;
        rx_d.ld_b  = 1'b0;
        rx_d.shift = 1'b0;
        rx_d.stop  = 1'b0;

        if (strobe_fall) begin
            // Frame boundary: close the old frame, open a new one.
            rx_d.stop = 1'b1;
            rx_d.cnt  = '0;
            rx_d.bad  = 1'b0;
            if (rx_q.cnt == CNT_FULL && !rx_q.bad && dir == DIR_WRITE) begin
                rx_d.wr_a = hit_a;
                rx_d.wr_b = hit_b;
            end
        end else if (bclk_rise) begin
            if (rx_q.cnt < CNT_FULL) begin
                rx_d.bits[rx_q.cnt[CNT_W-1:0]] = data_lvl;
                if (rx_q.cnt == '0 && strobe_lvl) begin
                    rx_d.bad = 1'b1;
                end
                if (rx_q.cnt >= CNT_SWITCH && !strobe_lvl) begin
                    rx_d.bad = 1'b1;
                end
            end
            if (rx_q.cnt != CNT_OVER) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end else if (bclk_fall) begin
            if (rx_q.cnt == CNT_ADDR) begin
                if (!rx_q.bad && dir == DIR_READ) begin
                    rx_d.ld_s = hit_a;
                    rx_d.ld_b = hit_b;
                end
            end else if (rx_q.cnt > CNT_ADDR) begin
                rx_d.shift = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_q.bad <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign wr_a      = rx_q.wr_a;
    assign wr_b      = rx_q.wr_b;
    assign wr_data   = rx_q.bits[FRAME_W-1:ADDR_W];
    assign ld_status = rx_q.ld_s;
    assign ld_regb   = rx_q.ld_b;
    assign rd_shift  = rx_q.shift;
    assign rd_stop   = rx_q.stop;

    // R5: a commit request only follows a frame of exactly FRAME_W bits
    assert_commit_full_frame_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.wr_a || rx_q.wr_b) |-> ($past(rx_q.cnt) == CNT_FULL));

    // R7: parallel capture happens only once the address is complete
    assert_capture_at_addr_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.ld_s || rx_q.ld_b) |-> (rx_q.cnt == CNT_ADDR));

    // R3: a request never targets both registers
    assert_single_target_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_q.wr_a, rx_q.wr_b, rx_q.ld_s, rx_q.ld_b}));
endmodule

// File: rtl/tw_regs.sv
module tw_regs
    import tw_pkg::*;
#(
    parameter int                DATA_W  = 24,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_status,
    input  logic              ld_regb,
    input  logic              rd_shift,
    input  logic              rd_stop,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic              sdo,
    output logic              sdo_en,
    output logic              commit,
    output logic              commit_sel
);
    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] shreg;
        logic              active;
        logic              commit;
        sel_e              sel;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d        = regs_q;
        regs_d.commit = wr_a | wr_b;
        if (wr_a) begin
            regs_d.a   = wr_data;
            regs_d.sel = SEL_A;
        end
        if (wr_b) begin
            regs_d.b   = wr_data;
            regs_d.sel = SEL_B;
        end

        if (rd_stop) begin
            regs_d.active = 1'b0;
        end else if (ld_status) begin
            regs_d.shreg  = status_word;
            regs_d.active = 1'b1;
        end else if (ld_regb) begin
            regs_d.shreg  = regs_q.b;
            regs_d.active = 1'b1;
        end else if (rd_shift && regs_q.active) begin
            regs_d.shreg = {1'b1, regs_q.shreg[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{a: RST_VAL, b: RST_VAL, shreg: '1, active: 1'b0,
                        commit: 1'b0, sel: SEL_A};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign reg_a      = regs_q.a;
    assign reg_b      = regs_q.b;
    assign sdo        = regs_q.active ? regs_q.shreg[0] : 1'b1;
    assign sdo_en     = regs_q.active;
    assign commit     = regs_q.commit;
    assign commit_sel = regs_q.sel;

    // R4: register A changes only after a write request for A
    assert_reg_a_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.a != $past(regs_q.a)) |-> $past(wr_a));

    // R4: register B changes only after a write request for B
    assert_reg_b_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.b != $past(regs_q.b)) |-> $past(wr_b));

    // R4: the commit strobe is never longer than one cycle
    assert_commit_pulse_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.commit |=> !regs_q.commit);

    // R7: the output enable rises only after a parallel capture
    assert_oe_after_load_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.active) |-> $past(ld_status || ld_regb));
endmodule

// File: rtl/tw_target.sv
module tw_target #(
    parameter int          ADDR_W        = 8,
    parameter int          DATA_W        = 24,
    parameter logic [7:0]  ADDR_A        = 8'h60,
    parameter logic [7:0]  ADDR_B        = 8'h62,
    parameter int          PERIOD_SWITCH = 4,
    parameter logic [23:0] RST_VAL       = 24'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sio_clk,
    input  logic              sio_period,
    input  logic              sio_data_in,
    input  logic [DATA_W-1:0] status_word,
    output logic              sio_data_out,
    output logic              sio_data_oe,
    output logic [DATA_W-1:0] ctrl_a,
    output logic [DATA_W-1:0] ctrl_b,
    output logic              commit_stb,
    output logic              commit_sel
);
    localparam int LINES    = 3;
    localparam int LN_CLK   = 0;
    localparam int LN_STROBE = 1;
    localparam int LN_DATA  = 2;

    logic [LINES-1:0]  lvl, rise, fall;
    logic              wr_a, wr_b, ld_status, ld_regb, rd_shift, rd_stop;
    logic [DATA_W-1:0] wr_data;

    tw_sync_edge #(
        .LINES (LINES),
        .IDLE  ('1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sio_data_in, sio_period, sio_clk}),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    tw_frame_rx #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .ADDR_A        (ADDR_W'(ADDR_A)),
        .ADDR_B        (ADDR_W'(ADDR_B)),
        .PERIOD_SWITCH (PERIOD_SWITCH)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (rise[LN_CLK]),
        .bclk_fall   (fall[LN_CLK]),
        .strobe_fall (fall[LN_STROBE]),
        .strobe_lvl  (lvl[LN_STROBE]),
        .data_lvl    (lvl[LN_DATA]),
        .wr_a        (wr_a),
        .wr_b        (wr_b),
        .wr_data     (wr_data),
        .ld_status   (ld_status),
        .ld_regb     (ld_regb),
        .rd_shift    (rd_shift),
        .rd_stop     (rd_stop)
    );

    tw_regs #(
        .DATA_W  (DATA_W),
        .RST_VAL (DATA_W'(RST_VAL))
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_a        (wr_a),
        .wr_b        (wr_b),
        .wr_data     (wr_data),
        .ld_status   (ld_status),
        .ld_regb     (ld_regb),
        .rd_shift    (rd_shift),
        .rd_stop     (rd_stop),
        .status_word (status_word),
        .reg_a       (ctrl_a),
        .reg_b       (ctrl_b),
        .sdo         (sio_data_out),
        .sdo_en      (sio_data_oe),
        .commit      (commit_stb),
        .commit_sel  (commit_sel)
    );
endmodule

// File: tb/tb_tw_target.sv
`timescale 1ns/1ps
module tb_tw_target;
    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [23:0] data;
        logic [5:0]  nbits;
        logic [1:0]  pmode;
        logic [23:0] st0;
        logic [23:0] st1;
        logic [23:0] exp_a;
        logic [23:0] exp_b;
        logic [23:0] exp_rd;
        logic        exp_oe;
        logic [1:0]  exp_commits;
        logic        exp_sel;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h60, 24'h123456, 6'd32, 2'd0, 24'h0, 24'h0, 24'h123456, 24'h000000, 24'hFFFFFF, 1'b0, 2'd1, 1'b0},
        '{1'b0, 8'h62, 24'hABCDEF, 6'd32, 2'd0, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd1, 1'b1},
        '{1'b1, 8'h61, 24'h000000, 6'd32, 2'd0, 24'h5A5A0F, 24'h000000, 24'h123456, 24'hABCDEF, 24'h5A5A0F, 1'b1, 2'd0, 1'b0},
        '{1'b1, 8'h63, 24'h000000, 6'd32, 2'd0, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hABCDEF, 1'b1, 2'd0, 1'b0},
        '{1'b0, 8'h64, 24'hFFFFFF, 6'd32, 2'd0, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd0, 1'b0},
        '{1'b0, 8'h60, 24'h000111, 6'd20, 2'd0, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd0, 1'b0},
        '{1'b0, 8'h60, 24'h00FF00, 6'd33, 2'd0, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd0, 1'b0},
        '{1'b0, 8'h60, 24'h777777, 6'd32, 2'd1, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd0, 1'b0},
        '{1'b0, 8'h62, 24'h777777, 6'd32, 2'd2, 24'h0, 24'h0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd0, 1'b0},
        '{1'b1, 8'h61, 24'h000000, 6'd32, 2'd1, 24'hC3C3C3, 24'hC3C3C3, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd0, 1'b0},
        '{1'b0, 8'h60, 24'h000001, 6'd32, 2'd0, 24'h0, 24'h0, 24'h000001, 24'hABCDEF, 24'hFFFFFF, 1'b0, 2'd1, 1'b0},
        '{1'b0, 8'h62, 24'h800000, 6'd32, 2'd0, 24'h0, 24'h0, 24'h000001, 24'h800000, 24'hFFFFFF, 1'b0, 2'd1, 1'b1},
        '{1'b1, 8'h63, 24'h000000, 6'd32, 2'd0, 24'h0, 24'h0, 24'h000001, 24'h800000, 24'h800000, 1'b1, 2'd0, 1'b0}
    };

    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sio_clk = 1'b1;
    logic        sio_period = 1'b1;
    logic        sio_data_in = 1'b1;
    logic [23:0] status_word = '0;
    logic        sio_data_out, sio_data_oe, commit_stb, commit_sel;
    logic [23:0] ctrl_a, ctrl_b;

    int checks = 0;
    int failures = 0;
    int ncommit = 0;
    logic last_sel = 1'b0;
    logic prev_stb = 1'b0;
    logic wide_stb = 1'b0;

    always #2.5 clk = ~clk;

    tw_target dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sio_clk      (sio_clk),
        .sio_period   (sio_period),
        .sio_data_in  (sio_data_in),
        .status_word  (status_word),
        .sio_data_out (sio_data_out),
        .sio_data_oe  (sio_data_oe),
        .ctrl_a       (ctrl_a),
        .ctrl_b       (ctrl_b),
        .commit_stb   (commit_stb),
        .commit_sel   (commit_sel)
    );

    always @(negedge clk) begin
        if (commit_stb) begin
            ncommit  <= ncommit + 1;
            last_sel <= commit_sel;
            if (prev_stb) wide_stb <= 1'b1;
        end
        prev_stb <= commit_stb;
    end

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic drive(input logic p, input logic c, input logic d);
        sio_period  = p;
        sio_clk     = c;
        sio_data_in = d;
        hold();
    endtask

    task automatic frame(input vec_t v, output logic [23:0] got_rd, output logic saw_oe,
                         output logic [23:0] pre_a, output logic [23:0] pre_b);
        int n;
        n      = v.rd ? 8 : int'(v.nbits);
        got_rd = '1;
        saw_oe = 1'b0;
        drive(1'b1, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        if (v.pmode == 2'd1) drive(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < n; i++) begin
            logic p, b;
            p = (i < 4) ? (v.pmode == 2'd1) : !(v.pmode == 2'd2 && i == 5);
            b = (i < 8) ? v.addr[i] : ((i - 8 < 24) ? v.data[i-8] : 1'b1);
            drive(p, 1'b0, b);
            drive(p, 1'b1, b);
        end
        if (v.rd) begin
            for (int j = 0; j < 24; j++) begin
                drive(1'b1, 1'b0, 1'b1);
                if (j == 0) status_word = v.st1;
                drive(1'b1, 1'b1, 1'b1);
                got_rd[j] = sio_data_out;
                saw_oe    = saw_oe | sio_data_oe;
            end
        end
        pre_a = ctrl_a;
        pre_b = ctrl_b;
        drive(1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.rd) return "R7";
        if (v.pmode != 2'd0) return "R6";
        if (v.nbits != 6'd32) return "R5";
        if (v.addr != 8'h60 && v.addr != 8'h62) return "R3";
        return "R2";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] model_a, model_b, got_rd, pre_a, pre_b;
        logic        saw_oe;
        int          c0;

        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1", "ctrl_a at reset", 32'(ctrl_a), 32'h0);
        check("R1", "ctrl_b at reset", 32'(ctrl_b), 32'h0);
        check("R1", "oe at reset", 32'(sio_data_oe), 32'h0);
        check("R1", "sdo at reset", 32'(sio_data_out), 32'h1);
        check("R1", "commit at reset", 32'(commit_stb), 32'h0);
        rst_n = 1'b1;
        hold();

        model_a = '0;
        model_b = '0;
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VECS[k];
            status_word = v.st0;
            c0 = ncommit;
            frame(v, got_rd, saw_oe, pre_a, pre_b);
            // R4: nothing visible before the strobe falls
            check("R4", "ctrl_a before frame end", 32'(pre_a), 32'(model_a));
            check("R4", "ctrl_b before frame end", 32'(pre_b), 32'(model_b));
            check(tag_of(v), "ctrl_a", 32'(ctrl_a), 32'(v.exp_a));
            // R9: the register not addressed keeps its value
            check("R9", "ctrl_b", 32'(ctrl_b), 32'(v.exp_b));
            check("R4", "commit count", 32'(ncommit - c0), 32'(v.exp_commits));
            if (v.exp_commits != 2'd0)
                check("R4", "commit_sel", 32'(last_sel), 32'(v.exp_sel));
            if (v.rd) begin
                // R8: snapshot source and stability
                check("R8", "read word", 32'(got_rd), 32'(v.exp_rd));
                check("R7", "oe during read", 32'(saw_oe), 32'(v.exp_oe));
                check("R7", "oe after frame", 32'(sio_data_oe), 32'h0);
            end
            model_a = v.exp_a;
            model_b = v.exp_b;
        end

        check("R4", "commit strobe wider than one cycle", 32'(wide_stb), 32'h0);
        check("R7", "sdo idle after reads", 32'(sio_data_out), 32'h1);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "ctrl_a after reset", 32'(ctrl_a), 32'h0);
        check("R1", "ctrl_b after reset", 32'(ctrl_b), 32'h0);
        check("R1", "oe after reset", 32'(sio_data_oe), 32'h0);
        rst_n = 1'b1;
        hold();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule